// File: doc/BRIEF.md
# Bus Lock Ownership Tracker

This block watches a shared parallel bus with several masters and keeps track of the exclusive-access lock. The lock is a resource of its own, separate from bus ownership. A master can keep the lock while other masters take turns driving transactions. The tracker samples the transaction-start strobe, the lock strobe and the identity of the master that currently owns the bus. It reports whether a lock exists and which master holds it.

A lock can be taken only in one place: the cycle right after a master first pulls the transaction strobe low. It is taken only if no lock exists yet. Only the holder can end the lock. When any other master tries to take the lock or to end it while a lock exists, the attempt is ignored and the tracker raises a one-cycle violation pulse. Arbitration, data movement and target decoding are handled elsewhere.

Top module: `bus_lock_tracker`

## Requirements
- R1: While `rst_n` is low, `lock_held`, `lock_owner` and `lock_violation` are all 0. After `rst_n` rises they stay 0 until the internal reset release has passed two clock edges.
- R2: A cycle where `frame_n` is sampled low and was sampled high at the previous edge starts a transaction. The next cycle is the claim window. If `lock_n` is sampled low in the claim window and no lock exists, then after that edge `lock_held` is 1 and `lock_owner` equals `bus_owner_id` from the claim window.
- R3: `lock_n` sampled low outside a claim window never creates a lock. This covers the start cycle itself and the later cycles of a long transaction.
- R4: Suppose a lock exists and a different master has `lock_n` low in a claim window. The claim is ignored: `lock_held` and `lock_owner` are unchanged, and `lock_violation` is 1 for the cycle after that edge.
- R5: The lock and its owner persist across changes of `bus_owner_id`. They also persist across transactions by other masters that do not claim.
- R6: A release is `lock_n` sampled high when it was sampled low at the previous edge. If the current bus owner equals `lock_owner`, the release clears `lock_held` and sets `lock_owner` to 0 at that edge.
- R7: A release by a bus owner other than `lock_owner`, while a lock exists, is ignored and pulses `lock_violation` for one cycle.
- R8: `lock_violation` is 1 only in a cycle that follows an ignored claim or release. A release while no lock exists produces no violation and no change.
- R9: A claim-window claim by the current holder leaves the lock unchanged and produces no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Transaction-start strobe, active low |
| lock_n | input | 1 | Lock strobe, active low |
| bus_owner_id | input | ID_W | Identity of the master that owns the bus in this cycle |
| lock_held | output | 1 | 1 while a lock exists |
| lock_owner | output | ID_W | Identity of the lock holder, 0 when no lock exists |
| lock_violation | output | 1 | One-cycle pulse after an ignored claim or release by a non-holder |

## Verification
The bench holds `lock_n` low in the start cycle and in later cycles of a long transaction. A design that opened the claim window at the wrong cycle would grant a lock there, or miss the real claim. Bus ownership is handed to another master while the lock line stays low, and that master then claims and releases. A design that tied the lock to bus ownership would move or drop the owner instead of pulsing a violation. The holder re-claims and then releases, and a release edge arrives with no lock present. These catch a tracker that flags its own holder, or that flags releases when nothing is held. A mid-run reset with the lock held checks that the clear is immediate and that a fresh claim works afterwards.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

  // Decoded strobe event for one sampled cycle
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_CLAIM   = 2'd1,
    LK_RELEASE = 2'd2
  } lock_evt_e;

endpackage

// File: rtl/blt_reset_sync.sv
module blt_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= 1'b1;
      end
      assign rst_n_sync = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/blt_strobe_sampler.sv
module blt_strobe_sampler
  import bus_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_n,
  input  logic      lock_n,
  output lock_evt_e evt
);

  logic frame_prev_q, frame_prev_d;
  logic lock_prev_q,  lock_prev_d;
  logic window_q,     window_d;
  logic txn_start;

  // next-state
  always_comb begin
    txn_start    = frame_prev_q & ~frame_n;
    window_d     = txn_start;
    frame_prev_d = frame_n;
    lock_prev_d  = lock_n;
    if (window_q && !lock_n)
      evt = LK_CLAIM;
    else if (!lock_prev_q && lock_n)
      evt = LK_RELEASE;
    else
      evt = LK_IDLE;
  end

  // registers; idle bus reads as strobes high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_prev_q <= 1'b1;
      lock_prev_q  <= 1'b1;
      window_q     <= 1'b0;
    end else begin
      frame_prev_q <= frame_prev_d;
      lock_prev_q  <= lock_prev_d;
      window_q     <= window_d;
    end
  end

  // R6: a release event always comes from a low-to-high lock strobe
  p_release_needs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LK_RELEASE) |-> (lock_n && $past(!lock_n)));

  // R3: a claim event needs a transaction start at the previous edge
  p_claim_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LK_CLAIM) |-> ($past(!frame_n) && !lock_n));

endmodule

// File: rtl/blt_owner_reg.sv
module blt_owner_reg
  import bus_lock_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  lock_evt_e       evt,
  input  logic [ID_W-1:0] bus_id,
  output logic            held,
  output logic [ID_W-1:0] owner,
  output logic            viol
);

  logic            held_q,  held_d;
  logic [ID_W-1:0] owner_q, owner_d;
  logic            viol_q,  viol_d;
  logic            is_holder;
  logic            upd_en;

  // next-state
  always_comb begin
    is_holder = held_q && (bus_id == owner_q);
    held_d    = held_q;
    owner_d   = owner_q;
    viol_d    = 1'b0;
    unique case (evt)
      LK_CLAIM: begin
        if (!held_q) begin
          held_d  = 1'b1;
          owner_d = bus_id;
        end else if (!is_holder) begin
          viol_d = 1'b1;
        end
      end
      LK_RELEASE: begin
        if (held_q) begin
          if (is_holder) begin
            held_d  = 1'b0;
            owner_d = '0;
          end else begin
            viol_d = 1'b1;
          end
        end
      end
      default: ;
    endcase
    upd_en = (evt != LK_IDLE) || viol_q;
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
      viol_q  <= 1'b0;
    end else if (upd_en) begin
      held_q  <= held_d;
      owner_q <= owner_d;
      viol_q  <= viol_d;
    end
  end

  assign held  = held_q;
  assign owner = owner_q;
  assign viol  = viol_q;

  // R2: free claim installs the claimant
  p_claim_installs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LK_CLAIM && !held) |=> (held && owner == $past(bus_id)));

  // R4: foreign claim ignored and flagged
  p_foreign_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LK_CLAIM && held && bus_id != owner) |=> (held && viol && $stable(owner)));

  // R5: lock persists unless a release event arrives
  p_lock_persists_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && evt != LK_RELEASE) |=> (held && $stable(owner)));

  // R6: holder release clears
  p_holder_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LK_RELEASE && held && bus_id == owner) |=> (!held && owner == '0 && !viol));

  // R7: foreign release ignored and flagged
  p_foreign_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LK_RELEASE && held && bus_id != owner) |=> (held && viol));

  // R8: a violation only follows a cycle with a lock present
  p_viol_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(held));

endmodule

// File: rtl/bus_lock_tracker.sv
module bus_lock_tracker
  import bus_lock_pkg::*;
#(
  parameter int ID_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            lock_n,
  input  logic [ID_W-1:0] bus_owner_id,
  output logic            lock_held,
  output logic [ID_W-1:0] lock_owner,
  output logic            lock_violation
);

  logic      rst_n_sync;
  lock_evt_e evt;

  blt_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  blt_strobe_sampler u_smp (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .frame_n (frame_n),
    .lock_n  (lock_n),
    .evt     (evt)
  );

  blt_owner_reg #(.ID_W(ID_W)) u_own (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .evt    (evt),
    .bus_id (bus_owner_id),
    .held   (lock_held),
    .owner  (lock_owner),
    .viol   (lock_violation)
  );

  // R1: outputs idle whenever reset is applied
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!lock_held && !lock_violation);
    end
  end

endmodule

// File: tb/bus_lock_tracker_tb.sv
module bus_lock_tracker_tb;

  localparam int ID_W  = 3;
  localparam int NVEC  = 21;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frame_n;
  logic            lock_n;
  logic [ID_W-1:0] bus_owner_id;
  logic            lock_held;
  logic [ID_W-1:0] lock_owner;
  logic            lock_violation;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_lock_tracker #(.ID_W(ID_W)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_n        (frame_n),
    .lock_n         (lock_n),
    .bus_owner_id   (bus_owner_id),
    .lock_held      (lock_held),
    .lock_owner     (lock_owner),
    .lock_violation (lock_violation)
  );

  // frame, lock, id, exp_held, exp_owner, exp_viol, req
  typedef struct packed {
    logic            f;
    logic            l;
    logic [ID_W-1:0] id;
    logic            eh;
    logic [ID_W-1:0] eo;
    logic            ev;
    logic [7:0]      req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 8'd3}, // idle
    '{1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 8'd3}, // start cycle
    '{1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 8'd2}, // R2 claim window, free
    '{1'b1, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 8'd5},
    '{1'b1, 1'b0, 3'd5, 1'b1, 3'd2, 1'b0, 8'd5}, // R5 bus handed to 5
    '{1'b0, 1'b0, 3'd5, 1'b1, 3'd2, 1'b0, 8'd3}, // start by 5, lock low not window
    '{1'b0, 1'b0, 3'd5, 1'b1, 3'd2, 1'b1, 8'd4}, // R4 foreign claim
    '{1'b1, 1'b0, 3'd5, 1'b1, 3'd2, 1'b0, 8'd8}, // R8 pulse ends
    '{1'b0, 1'b1, 3'd5, 1'b1, 3'd2, 1'b1, 8'd7}, // R7 foreign release
    '{1'b0, 1'b1, 3'd5, 1'b1, 3'd2, 1'b0, 8'd5}, // window, no claim
    '{1'b1, 1'b1, 3'd5, 1'b1, 3'd2, 1'b0, 8'd5},
    '{1'b1, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 8'd5},
    '{1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 8'd9},
    '{1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 8'd9}, // R9 holder re-claims
    '{1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 8'd6}, // R6 holder release
    '{1'b1, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 8'd6},
    '{1'b1, 1'b0, 3'd3, 1'b0, 3'd0, 1'b0, 8'd3}, // R3 lock low, no window
    '{1'b1, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 8'd8}, // R8 release with no lock
    '{1'b0, 1'b0, 3'd7, 1'b0, 3'd0, 1'b0, 8'd3}, // R3 lock low in start cycle
    '{1'b0, 1'b0, 3'd7, 1'b1, 3'd7, 1'b0, 8'd2}, // R2 claim by 7
    '{1'b1, 1'b0, 3'd7, 1'b1, 3'd7, 1'b0, 8'd5}
  };

  task automatic check(input string tag, input logic eh, input logic [ID_W-1:0] eo,
                       input logic ev);
    n_checks++;
    if (lock_held !== eh || lock_owner !== eo || lock_violation !== ev) begin
      n_fail++;
      $display("FAIL %s: held/owner/viol got %b/%0d/%b exp %b/%0d/%b", tag,
               lock_held, lock_owner, lock_violation, eh, eo, ev);
    end
  endtask

  task automatic drive(input logic f, input logic l, input logic [ID_W-1:0] id);
    @(negedge clk);
    frame_n      = f;
    lock_n       = l;
    bus_owner_id = id;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n        = 1'b0;
    frame_n      = 1'b1;
    lock_n       = 1'b1;
    bus_owner_id = '0;
    #1;
    check("R1 during reset", 1'b0, '0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", 1'b0, '0, 1'b0);
  endtask

  initial begin
    rst_n        = 1'b0;
    frame_n      = 1'b1;
    lock_n       = 1'b1;
    bus_owner_id = '0;
    do_reset();

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].f, VECS[i].l, VECS[i].id);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].eh, VECS[i].eo, VECS[i].ev);
    end

    // R1: reset mid-run with the lock held clears at once
    do_reset();

    // R2 after reset: fresh claim by master 1
    drive(1'b0, 1'b1, 3'd1);
    drive(1'b0, 1'b0, 3'd1);
    check("R2 claim after reset", 1'b1, 3'd1, 1'b0);

    // R3: long transaction, lock low only in its third cycle; first release it
    drive(1'b1, 1'b1, 3'd1);
    check("R6 release before long txn", 1'b0, '0, 1'b0);
    drive(1'b0, 1'b1, 3'd4);
    drive(1'b0, 1'b1, 3'd4);
    drive(1'b0, 1'b0, 3'd4);
    check("R3 late lock in long txn", 1'b0, '0, 1'b0);
    drive(1'b1, 1'b1, 3'd4);
    check("R8 idle release no lock", 1'b0, '0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule